// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a parameterized bank of 32-bit event counters. Each counter is given an event-type number that picks what it counts. It can count retired-instruction strobes, processor-cycle strobes, or increments requested by software through a register write. A counter advances only while the global enable bit is set and its own bit in the counter-enable mask is set.

When a counter wraps past bit 31, it sets its sticky bit in the overflow status mask. Three masks (counter enable, overflow status and interrupt enable) each have a write-one-to-set address and a write-one-to-clear address. The single level-sensitive interrupt output is high while the global enable is on and at least one overflow bit is also interrupt-enabled.

The block is driven through a simple register port that takes a single-cycle write strobe and returns read data combinationally. Software writes the event types and counter values through this port, reads the counts back, and handles the interrupt by clearing the overflow bits that caused it.

Top module: `event_counter_bank`

## Requirements
- R1: After reset all counters, event types, masks and the global enable are zero, and `irq` is low.
- R2: Counter i increments by one on each clock with `instStrobe` high when its type is 0x008, and on each clock with `cycStrobe` high when its type is 0x011. This happens only while the global enable (bit 0 of the control register at address 0x00) and bit i of the enable mask are both 1. Any other type ignores both strobes.
- R3: A counter overflows when an increment takes it from bit 31 set to bit 31 clear. The overflow sets bit i of the overflow mask, and the bit stays set until software clears it. A counter only wraps: it never saturates or stops.
- R4: A write to address 0x07 (software increment) adds one to every counter i whose bit is 1 in the written data, provided counter i is enabled and its type is 0x000. Overflow detection applies to these increments.
- R5: Addresses 0x01/0x02 set and clear the enable mask, 0x03/0x04 set and clear the overflow mask, and 0x05/0x06 set and clear the interrupt-enable mask. Ones in the data OR in or clear bits, and writes are first limited to bits 0..N-1 plus bit 31. Each address of a pair reads back the mask.
- R6: `irq` equals global enable AND the OR of (interrupt-enable mask AND overflow mask). It reflects a mask write or a new overflow on the clock edge that records it.
- R7: The control register at 0x00 reads the global enable at bit 0 and the counter count N at bits 15:11. Only bit 0 is writable.
- R8: Counter values live at 0x10+i and event types (10 bits) at 0x20+i. Writes to indices at or above N are ignored, and reads of them return zero.
- R9: An overflow-set write and a hardware overflow in the same cycle both take effect.
- R10: A register write to a counter loads the value and never records an overflow, even when it clears bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instStrobe | input | 1 | One instruction retired this cycle |
| cycStrobe | input | 1 | One processor cycle elapsed |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
The bench sweeps every counter against every event type and checks the counts of both strobes. A design with a swapped type decode, or one that ignores the enable gating, would show wrong totals. It crosses all 32 overflow patterns with all 32 interrupt-enable patterns under both global-enable settings, which exposes a wrong reduction or a missing gate on `irq`. It drives the boundary cases around bit 31: 0xFFFFFFFF to 0, 0x7FFFFFFF to 0x80000000, a wrap caused by a software increment, and a register write that clears bit 31. A design that flags the wrong transition, or treats the load as an overflow, would flag the wrong case. It also places an overflow-set write on the same edge as a hardware overflow, and aims writes at indices past N, where a lost bit or an aliased counter becomes visible.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int TYPE_W = 10;
  localparam int IDX_W  = 4;
  localparam int CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET = 6'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h02;
  localparam logic [ADDR_W-1:0] A_OV_SET = 6'h03;
  localparam logic [ADDR_W-1:0] A_OV_CLR = 6'h04;
  localparam logic [ADDR_W-1:0] A_IE_SET = 6'h05;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 6'h06;
  localparam logic [ADDR_W-1:0] A_SWINC  = 6'h07;

  localparam logic [1:0] GRP_MISC = 2'b00;
  localparam logic [1:0] GRP_CTR  = 2'b01;
  localparam logic [1:0] GRP_TYP  = 2'b10;

  localparam logic [TYPE_W-1:0] EV_SOFT = 10'h000;
  localparam logic [TYPE_W-1:0] EV_INST = 10'h008;
  localparam logic [TYPE_W-1:0] EV_CYC  = 10'h011;

  typedef struct packed {
    logic              ctlWr;
    logic              enSet;
    logic              enClr;
    logic              ovSet;
    logic              ovClr;
    logic              ieSet;
    logic              ieClr;
    logic              swInc;
    logic              ctrWr;
    logic              typWr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] maskData;
  } ctrlStrb_t;
endpackage

// File: rtl/ecb_ctrl.sv
module ecb_ctrl
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWdata,
  input  logic                      gEn,
  input  logic [DATA_W-1:0]         enMask,
  input  logic [DATA_W-1:0]         ovfMask,
  input  logic [DATA_W-1:0]         ieMask,
  input  logic [NUM_CTR*DATA_W-1:0] ctrFlat,
  input  logic [NUM_CTR*TYPE_W-1:0] typFlat,
  output ctrlStrb_t                 strb,
  output logic [DATA_W-1:0]         regRdata
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    ((32'd1 << NUM_CTR) - 32'd1) | (32'd1 << CYC_BIT);
  localparam logic [4:0] NUM_FIELD = 5'(NUM_CTR);

  logic [IDX_W-1:0] idx;
  logic             idxOk;
  logic [1:0]       grp;

  assign idx   = regAddr[IDX_W-1:0];
  assign grp   = regAddr[ADDR_W-1:IDX_W];
  assign idxOk = ({28'd0, idx} < 32'(NUM_CTR));

  // write decode into a strobe bundle for the datapath
  always_comb begin
    strb          = '0;
    strb.idx      = idx;
    strb.data     = regWdata;
    strb.maskData = regWdata & IMPL_MASK;
    if (regWe) begin
      case (regAddr)
        A_CTRL:   strb.ctlWr = 1'b1;
        A_EN_SET: strb.enSet = 1'b1;
        A_EN_CLR: strb.enClr = 1'b1;
        A_OV_SET: strb.ovSet = 1'b1;
        A_OV_CLR: strb.ovClr = 1'b1;
        A_IE_SET: strb.ieSet = 1'b1;
        A_IE_CLR: strb.ieClr = 1'b1;
        A_SWINC:  strb.swInc = 1'b1;
        default:  ;
      endcase
      if (grp == GRP_CTR && idxOk) strb.ctrWr = 1'b1;
      if (grp == GRP_TYP && idxOk) strb.typWr = 1'b1;
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (grp == GRP_MISC) begin
      case (idx)
        4'h0:       regRdata = {16'd0, NUM_FIELD, 10'd0, gEn};
        4'h1, 4'h2: regRdata = enMask;
        4'h3, 4'h4: regRdata = ovfMask;
        4'h5, 4'h6: regRdata = ieMask;
        default:    regRdata = '0;
      endcase
    end else if (grp == GRP_CTR && idxOk) begin
      regRdata = ctrFlat[int'(idx)*DATA_W +: DATA_W];
    end else if (grp == GRP_TYP && idxOk) begin
      regRdata = {{(DATA_W-TYPE_W){1'b0}}, typFlat[int'(idx)*TYPE_W +: TYPE_W]};
    end
  end
endmodule

// File: rtl/ecb_datapath.sv
module ecb_datapath
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrb_t                 strb,
  input  logic                      instStrobe,
  input  logic                      cycStrobe,
  output logic                      gEn,
  output logic [DATA_W-1:0]         enMask,
  output logic [DATA_W-1:0]         ovfMask,
  output logic [DATA_W-1:0]         ieMask,
  output logic [NUM_CTR*DATA_W-1:0] ctrFlat,
  output logic [NUM_CTR*TYPE_W-1:0] typFlat,
  output logic                      irq
);
  logic [NUM_CTR-1:0] newOvf;
  logic [DATA_W-1:0]  newOvfW;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [DATA_W-1:0] ctr;
    logic [TYPE_W-1:0] typ;
    logic              enabled;
    logic              hwHit;
    logic              swHit;
    logic [1:0]        inc;
    logic [DATA_W-1:0] sum;
    logic              wrHere;
    logic              typHere;

    assign wrHere  = strb.ctrWr && (int'(strb.idx) == i);
    assign typHere = strb.typWr && (int'(strb.idx) == i);

    always_comb begin
      enabled = gEn & enMask[i];
      hwHit   = enabled & (((typ == EV_INST) & instStrobe) |
                           ((typ == EV_CYC)  & cycStrobe));
      swHit   = enabled & strb.swInc & strb.maskData[i] & (typ == EV_SOFT);
      inc     = {1'b0, hwHit} + {1'b0, swHit};
      sum     = ctr + {30'd0, inc};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        ctr <= '0;
      else if (wrHere)  ctr <= strb.data;
      else              ctr <= sum;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        typ <= '0;
      else if (typHere) typ <= strb.data[TYPE_W-1:0];
    end

    // wrap past bit 31 caused by counting, never by a load
    assign newOvf[i] = !wrHere & ctr[DATA_W-1] & !sum[DATA_W-1];
    assign ctrFlat[i*DATA_W +: DATA_W] = ctr;
    assign typFlat[i*TYPE_W +: TYPE_W] = typ;
  end

  assign newOvfW = {{(DATA_W-NUM_CTR){1'b0}}, newOvf};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn     <= 1'b0;
      enMask  <= '0;
      ovfMask <= '0;
      ieMask  <= '0;
    end else begin
      if (strb.ctlWr) gEn <= strb.data[0];
      if (strb.enSet)      enMask <= enMask | strb.maskData;
      else if (strb.enClr) enMask <= enMask & ~strb.maskData;
      if (strb.ieSet)      ieMask <= ieMask | strb.maskData;
      else if (strb.ieClr) ieMask <= ieMask & ~strb.maskData;
      ovfMask <= (ovfMask & ~(strb.ovClr ? strb.maskData : '0))
               | (strb.ovSet ? strb.maskData : '0)
               | newOvfW;
    end
  end

  assign irq = gEn & (|(ieMask & ovfMask));
endmodule

// File: rtl/event_counter_bank.sv
module event_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instStrobe,
  input  logic              cycStrobe,
  input  logic              regWe,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  ctrlStrb_t                 strb;
  logic                      gEn;
  logic [DATA_W-1:0]         enMask;
  logic [DATA_W-1:0]         ovfMask;
  logic [DATA_W-1:0]         ieMask;
  logic [NUM_CTR*DATA_W-1:0] ctrFlat;
  logic [NUM_CTR*TYPE_W-1:0] typFlat;

  ecb_ctrl #(.NUM_CTR(NUM_CTR)) u_ctrl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .gEn      (gEn),
    .enMask   (enMask),
    .ovfMask  (ovfMask),
    .ieMask   (ieMask),
    .ctrFlat  (ctrFlat),
    .typFlat  (typFlat),
    .strb     (strb),
    .regRdata (regRdata)
  );

  ecb_datapath #(.NUM_CTR(NUM_CTR)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .instStrobe (instStrobe),
    .cycStrobe  (cycStrobe),
    .gEn        (gEn),
    .enMask     (enMask),
    .ovfMask    (ovfMask),
    .ieMask     (ieMask),
    .ctrFlat    (ctrFlat),
    .typFlat    (typFlat),
    .irq        (irq)
  );
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input ctrlStrb_t                 strb,
  input logic                      gEn,
  input logic [DATA_W-1:0]         enMask,
  input logic [DATA_W-1:0]         ovfMask,
  input logic [DATA_W-1:0]         ieMask,
  input logic [NUM_CTR*DATA_W-1:0] ctrFlat,
  input logic                      irq
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    ((32'd1 << NUM_CTR) - 32'd1) | (32'd1 << CYC_BIT);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> gEn);

  // R5
  mask_impl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((enMask | ovfMask | ieMask) & ~IMPL_MASK) == '0);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.ovClr) |-> ((ovfMask & $past(ovfMask)) == $past(ovfMask)));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!(gEn && enMask[i]) && !(strb.ctrWr && int'(strb.idx) == i))
      |=> $stable(ctrFlat[i*DATA_W +: DATA_W]));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(ctrFlat[i*DATA_W + DATA_W-1]) && !ctrFlat[i*DATA_W + DATA_W-1]
       && !$past(strb.ctrWr && int'(strb.idx) == i)) |-> ovfMask[i]);
  end
endmodule

bind event_counter_bank ecb_chk #(.NUM_CTR(NUM_CTR)) u_ecbChk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .gEn     (gEn),
  .enMask  (enMask),
  .ovfMask (ovfMask),
  .ieMask  (ieMask),
  .ctrFlat (ctrFlat),
  .irq     (irq)
);

// File: tb/test_event_counter_bank.sv
module test_event_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCTR = 4;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instStrobe = 1'b0;
  logic        cycStrobe = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_counter_bank #(.NUM_CTR(NCTR)) i_event_counter_bank (
    .clk(clk), .rstN(rstN), .instStrobe(instStrobe), .cycStrobe(cycStrobe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(string req, logic [5:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic pulse(bit i, bit c, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instStrobe = i; cycStrobe = c;
    end
    @(negedge clk);
    instStrobe = 1'b0; cycStrobe = 1'b0;
  endtask

  function automatic logic [31:0] expand(logic [4:0] v);
    return {v[4], 27'd0, v[3:0]};
  endfunction

  task automatic clearAll();
    wr(6'h00, 32'd0);
    wr(6'h02, ALL);
    wr(6'h04, ALL);
    wr(6'h06, ALL);
    for (int i = 0; i < NCTR; i++) begin
      wr(6'(32'h10 + i), 32'd0);
      wr(6'(32'h20 + i), 32'd0);
    end
  endtask

  task automatic finish();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish();
    end
  end

  initial begin
    logic [9:0]  types [4];
    logic [31:0] exp;
    types[0] = 10'h000; types[1] = 10'h008; types[2] = 10'h011; types[3] = 10'h005;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R7 control field
    rdChk("R1 control", 6'h00, 32'h0000_2000);
    rdChk("R1 enable mask", 6'h01, 32'd0);
    rdChk("R1 overflow mask", 6'h03, 32'd0);
    rdChk("R1 irq-enable mask", 6'h05, 32'd0);
    for (int i = 0; i < NCTR; i++) begin
      rdChk("R1 counter", 6'(32'h10 + i), 32'd0);
      rdChk("R1 type", 6'(32'h20 + i), 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R7 only bit 0 writable
    wr(6'h00, ALL);
    rdChk("R7 control write", 6'h00, 32'h0000_2001);
    wr(6'h00, 32'd0);
    rdChk("R7 control clear", 6'h00, 32'h0000_2000);

    // R5 set/clear sweep over every bit of each mask
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 32; b++) begin
        logic [31:0] bit1;
        bit1 = 32'd1 << b;
        wr(6'(1 + 2*m), bit1);
        rdChk("R5 set", 6'(1 + 2*m), bit1 & 32'h8000_000F);
        rdChk("R5 readback", 6'(2 + 2*m), bit1 & 32'h8000_000F);
        wr(6'(2 + 2*m), ALL);
        rdChk("R5 clear", 6'(1 + 2*m), 32'd0);
      end
    end

    // R6 interrupt level across overflow x irq-enable patterns
    for (int g = 0; g < 2; g++) begin
      wr(6'h00, 32'(g));
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          wr(6'h04, ALL);
          wr(6'h03, expand(5'(a)));
          wr(6'h06, ALL);
          wr(6'h05, expand(5'(b)));
          chk("R6 irq level", {31'd0, irq},
              {31'd0, (g == 1) && ((a & b) != 0)});
        end
      end
    end

    // R2 counting per counter and type, gating by enables
    clearAll();
    wr(6'h00, 32'd1);
    for (int i = 0; i < NCTR; i++) begin
      for (int t = 0; t < 4; t++) begin
        wr(6'h02, ALL);
        wr(6'(32'h20 + i), {22'd0, types[t]});
        wr(6'(32'h10 + i), 32'h100);
        wr(6'h01, 32'd1 << i);
        pulse(1'b1, 1'b1, 3);
        pulse(1'b0, 1'b1, 5);
        exp = 32'h100 + ((t == 1) ? 32'd3 : (t == 2) ? 32'd8 : 32'd0);
        rdChk("R2 count", 6'(32'h10 + i), exp);
        wr(6'h00, 32'd0);
        pulse(1'b1, 1'b1, 4);
        rdChk("R2 global disable hold", 6'(32'h10 + i), exp);
        wr(6'h00, 32'd1);
        wr(6'h02, 32'd1 << i);
        pulse(1'b1, 1'b1, 4);
        rdChk("R2 counter disable hold", 6'(32'h10 + i), exp);
      end
    end

    // R3 wrap at bit 31, sticky flag
    clearAll();
    wr(6'h00, 32'd1);
    wr(6'h20, 32'h008);
    wr(6'h10, 32'hFFFF_FFFE);
    wr(6'h01, 32'd1);
    pulse(1'b1, 1'b0, 1);
    rdChk("R3 before wrap", 6'h10, 32'hFFFF_FFFF);
    rdChk("R3 no flag yet", 6'h03, 32'd0);
    pulse(1'b1, 1'b0, 1);
    rdChk("R3 wrapped", 6'h10, 32'd0);
    rdChk("R3 flag set", 6'h03, 32'd1);
    chk("R6 irq masked off", {31'd0, irq}, 32'd0);
    wr(6'h05, 32'd1);
    chk("R6 irq after enable", {31'd0, irq}, 32'd1);
    wr(6'h10, 32'h7FFF_FFFF);
    pulse(1'b1, 1'b0, 1);
    rdChk("R3 half crossing", 6'h10, 32'h8000_0000);
    rdChk("R3 flag sticky", 6'h03, 32'd1);
    wr(6'h04, 32'd1);
    rdChk("R3 flag cleared", 6'h03, 32'd0);
    chk("R6 irq after clear", {31'd0, irq}, 32'd0);
    pulse(1'b1, 1'b0, 2);
    rdChk("R3 no false flag", 6'h03, 32'd0);

    // R10 load clearing bit 31 is not an overflow
    wr(6'h10, 32'd5);
    rdChk("R10 loaded", 6'h10, 32'd5);
    rdChk("R10 no flag on load", 6'h03, 32'd0);

    // R4 software increment
    clearAll();
    wr(6'h00, 32'd1);
    wr(6'h22, 32'h008);
    wr(6'h10, 32'd5);
    wr(6'h11, 32'd7);
    wr(6'h12, 32'd9);
    wr(6'h13, 32'hFFFF_FFFF);
    wr(6'h01, 32'b1101);
    wr(6'h07, ALL);
    rdChk("R4 enabled soft counter", 6'h10, 32'd6);
    rdChk("R4 disabled counter held", 6'h11, 32'd7);
    rdChk("R4 other type held", 6'h12, 32'd9);
    rdChk("R4 soft wrap", 6'h13, 32'd0);
    rdChk("R4 soft overflow flag", 6'h03, 32'h8);
    wr(6'h07, 32'd1);
    rdChk("R4 selected only", 6'h10, 32'd7);
    rdChk("R4 unselected held", 6'h13, 32'd0);

    // R9 overflow-set write with hardware overflow in one cycle
    clearAll();
    wr(6'h00, 32'd1);
    wr(6'h20, 32'h008);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h01, 32'd1);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'h03; regWdata = 32'd2; instStrobe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; instStrobe = 1'b0;
    rdChk("R9 both flags", 6'h03, 32'd3);
    rdChk("R9 counter wrapped", 6'h10, 32'd0);

    // R8 out-of-range indices
    wr(6'h14, 32'h1234);
    rdChk("R8 read beyond N", 6'h14, 32'd0);
    rdChk("R8 read top index", 6'h1F, 32'd0);
    rdChk("R8 no alias", 6'h10, 32'd0);
    wr(6'h25, 32'h008);
    rdChk("R8 type beyond N", 6'h25, 32'd0);
    rdChk("R8 type kept", 6'h20, 32'h008);

    finish();
  end
endmodule